// File: doc/BRIEF.md
# LCD Modulation Signal Generator

This block produces the alternating-polarity drive signal that a passive LCD panel needs so that no pixel sees a net DC voltage. It watches three timing strobes from the panel timing logic: a line-clock pulse, a first-line marker, and a pulse marking the second line-clock edge inside each row. An 8-bit rate value selects how often the output flips.

With a rate of zero the output flips once per frame. The flip happens in the cycle where the line-clock pulse coincides with the first-line marker, which is when the marker is latched. With a nonzero rate N the output flips on every N-th second-edge strobe. The row count restarts at every frame start. The rate value is not used directly. It is captured into an active copy only at a flip or at a frame start, so a rate written mid-period can never leave the row counter past its limit.

Top module: `lcd_mod_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `mod_o` is 0, the row count is 0 and the active rate is 0, which is zero mode.
- R2: In zero mode, a frame latch event (`line_pulse_i` and `first_line_i` both 1 in the same cycle) inverts `mod_o` on the following clock edge. Each such event causes exactly one inversion.
- R3: `line_pulse_i` without `first_line_i`, or `first_line_i` without `line_pulse_i`, leaves `mod_o` unchanged.
- R4: With active rate N greater than 0, `mod_o` inverts on the clock edge after every N-th `row_edge_i` pulse, counted from the last inversion or frame latch.
- R5: In zero mode, `row_edge_i` pulses have no effect on `mod_o`.
- R6: With a nonzero active rate, a frame latch event does not invert `mod_o`. It restarts the row count at zero.
- R7: `rate_i` is copied into the active rate only in a cycle with a frame latch event or an inversion. A change at any other time waits for the next of these.
- R8: With a nonzero active rate the row count stays below that rate. In zero mode the count stays at 0.
- R9: The rate boundaries behave as specified: with N=1 every `row_edge_i` inverts `mod_o`, and with N=255 only the 255th does.
- R10: When a frame latch event and a `row_edge_i` pulse arrive in the same cycle with a nonzero rate, the frame latch wins. No inversion occurs and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_pulse_i | input | 1 | One-cycle line-clock strobe |
| first_line_i | input | 1 | First-line marker, latched when the line-clock strobe is high |
| row_edge_i | input | 1 | One-cycle strobe at the second line-clock edge of a row |
| rate_i | input | 8 | Modulation rate: 0 selects once per frame, N selects every N rows |
| mod_o | output | 1 | Registered modulation output |

## Verification
Every result of this block is due one clock edge after the strobe that causes it, because `mod_o` is a single register fed from the event decode. A strobe that causes no inversion shows up as an unchanged `mod_o` at that same edge. The driver applies one strobe pattern per cycle at the falling edge. It pushes the value expected after the next rising edge into a queue, and the monitor pops and compares at the falling edge after that. Rate values are driven together with strobes, so the one-cycle capture point of R7 is tested against the same timing.

// File: rtl/lcd_mod_pkg.sv
package lcd_mod_pkg;
  localparam int unsigned RATE_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/lcd_mod_rstsync.sv
module lcd_mod_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_mod_evt.sv
module lcd_mod_evt #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              line_pulse,
  input  logic              first_line,
  input  logic              row_edge,
  input  logic [RATE_W-1:0] rate_act,
  output logic              frame_ev,
  output logic              edge_ev,
  output logic              zero_mode
);
  always_comb begin
    frame_ev  = line_pulse & first_line;
    zero_mode = (rate_act == '0);
    // frame restart outranks a coincident row strobe
    edge_ev   = row_edge & ~zero_mode & ~frame_ev;
  end
endmodule

// File: rtl/lcd_mod_rowcnt.sv
module lcd_mod_rowcnt #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ev,
  input  logic              edge_ev,
  input  logic [RATE_W-1:0] rate_act,
  output logic              hit,
  output logic [RATE_W-1:0] cnt
);
  localparam int unsigned EXT_W = RATE_W + 1;

  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] cnt_d;
  logic              cnt_en;
  logic [EXT_W-1:0]  cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    hit     = edge_ev & (cnt_inc == {1'b0, rate_act});
    cnt_en  = frame_ev | edge_ev;
    if (frame_ev || hit) cnt_d = '0;
    else                 cnt_d = cnt_inc[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lcd_mod_gen.sv
module lcd_mod_gen #(
  parameter int unsigned RATE_W      = lcd_mod_pkg::RATE_W_DEF,
  parameter int unsigned SYNC_STAGES = lcd_mod_pkg::SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse_i,
  input  logic              first_line_i,
  input  logic              row_edge_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              mod_o
);
  logic              rst_sync_n;
  logic              frame_ev;
  logic              edge_ev;
  logic              zero_mode;
  logic              row_hit;
  logic [RATE_W-1:0] row_cnt;
  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] rate_d;
  logic              rate_en;
  logic              mod_q;
  logic              mod_d;
  logic              toggle;

  lcd_mod_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_mod_evt #(.RATE_W(RATE_W)) u_evt (
    .line_pulse (line_pulse_i),
    .first_line (first_line_i),
    .row_edge   (row_edge_i),
    .rate_act   (rate_q),
    .frame_ev   (frame_ev),
    .edge_ev    (edge_ev),
    .zero_mode  (zero_mode)
  );

  lcd_mod_rowcnt #(.RATE_W(RATE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .frame_ev (frame_ev),
    .edge_ev  (edge_ev),
    .rate_act (rate_q),
    .hit      (row_hit),
    .cnt      (row_cnt)
  );

  always_comb begin
    toggle  = (zero_mode & frame_ev) | row_hit;
    mod_d   = ~mod_q;
    rate_en = frame_ev | toggle;
    rate_d  = rate_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mod_q <= 1'b0;
    else if (toggle) mod_q <= mod_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rate_q <= '0;
    else if (rate_en) rate_q <= rate_d;
  end

  assign mod_o = mod_q;
endmodule

// File: rtl/lcd_mod_chk.sv
module lcd_mod_chk #(
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_pulse,
  input logic              first_line,
  input logic              row_edge,
  input logic [RATE_W-1:0] rate_in,
  input logic [RATE_W-1:0] rate_act,
  input logic [RATE_W-1:0] cnt,
  input logic              mod
);
  logic fl;
  assign fl = line_pulse & first_line;

  assert_zero_frame_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_act == '0 && fl) |=> (mod != $past(mod)));

  assert_partial_latch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl && !row_edge) |=> $stable(mod));

  assert_zero_mode_row_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_act == '0 && !fl) |=> $stable(mod));

  assert_frame_no_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_act != '0 && fl) |=> ($stable(mod) && cnt == '0));

  assert_rate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl && !row_edge) |=> $stable(rate_act));

  assert_rate_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (rate_act == $past(rate_in)));

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_act == '0) ? (cnt == '0) : (cnt < rate_act));
endmodule

bind lcd_mod_gen lcd_mod_chk #(.RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .line_pulse (line_pulse_i),
  .first_line (first_line_i),
  .row_edge   (row_edge_i),
  .rate_in    (rate_i),
  .rate_act   (rate_q),
  .cnt        (row_cnt),
  .mod        (mod_o)
);

// File: tb/lcd_mod_gen_tb.sv
module lcd_mod_gen_tb;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       line_pulse_i;
  logic       first_line_i;
  logic       row_edge_i;
  logic [7:0] rate_i;
  logic       mod_o;

  int    n_vec;
  int    n_bad;
  item_t sb[$];

  logic m_mod;
  int   m_rate;
  int   m_cnt;
  int   r_cfg;

  lcd_mod_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_pulse_i (line_pulse_i),
    .first_line_i (first_line_i),
    .row_edge_i   (row_edge_i),
    .rate_i       (rate_i),
    .mod_o        (mod_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (mod_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s: mod_o=%0b expected %0b at %0t", it.tag, mod_o, it.exp, $time);
      end
    end
  end

  task automatic step(input logic l, input logic f, input logic e, input string tag);
    logic fe;
    @(negedge clk);
    line_pulse_i = l;
    first_line_i = f;
    row_edge_i   = e;
    rate_i       = 8'(r_cfg);
    fe = l & f;
    @(posedge clk);
    if (m_rate == 0) begin
      if (fe) begin m_mod = ~m_mod; m_rate = r_cfg; end
    end else if (fe) begin
      m_cnt = 0; m_rate = r_cfg;
    end else if (e) begin
      if (m_cnt + 1 == m_rate) begin
        m_mod = ~m_mod; m_cnt = 0; m_rate = r_cfg;
      end else m_cnt++;
    end
    sb.push_back('{exp: m_mod, tag: tag});
  endtask

  task automatic rows(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, 1'b1, tag);
      step(1'b0, 1'b0, 1'b0, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_mod = 1'b0; m_rate = 0; m_cnt = 0; r_cfg = 0;
    line_pulse_i = 1'b0; first_line_i = 1'b0; row_edge_i = 1'b0; rate_i = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (mod_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: mod_o=%0b during reset expected 0", mod_o);
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, "R1");

    // zero mode, once per frame
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, "R3");
    rows(3, "R5");
    step(1'b1, 1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");

    // enter rate 3 via frame latch
    r_cfg = 3;
    step(1'b1, 1'b1, 1'b0, "R7");
    rows(6, "R4");
    // frame restart mid-period
    rows(2, "R6");
    step(1'b1, 1'b1, 1'b0, "R6");
    rows(3, "R6");
    step(1'b0, 1'b1, 1'b0, "R3");
    // rate change mid-period waits for next flip
    rows(1, "R7");
    r_cfg = 1;
    rows(2, "R7");
    rows(4, "R9");
    // boundary 255
    r_cfg = 255;
    rows(1, "R9");
    rows(254, "R9");
    rows(1, "R9");
    // coincident frame latch and row edge
    r_cfg = 2;
    rows(3, "R10");
    step(1'b1, 1'b1, 1'b1, "R10");
    rows(2, "R10");
    // back to zero mode at next flip
    r_cfg = 0;
    rows(1, "R7");
    rows(1, "R7");
    rows(2, "R5");
    step(1'b1, 1'b1, 1'b0, "R2");
    repeat (2) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule